// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Cache with Age-Rank Replacement

This block is a data cache that sits between a processor and a word-wide memory. It holds 256 sets of four ways, and each way holds one 32-bit word. A lookup compares all four stored tags of the selected set in one cycle. When one of them matches, the word comes back in the same cycle with no stall. A write that hits updates only the cached copy and marks it dirty. Memory is brought up to date only when that line is evicted.

On a miss the block stalls the processor. It picks a victim way: any invalid way first, otherwise the way that was used least recently in that set. If the victim is dirty, its word is written to memory first. The missing word is then read into the way. The processor keeps its request asserted throughout, and the retried lookup then hits. A write miss works the same way: it allocates the line, and the retry merges the write data and sets the dirty flag.

Recency is tracked per set with a 2-bit age rank for each way. Rank 0 is the most recent and rank 3 the least. The ranks of a set always form a permutation of 0..3.

Top module: `assoc_cache4`

## Requirements
- R1: An address splits into a word offset in bits [1:0], a set index in bits [9:2] and a tag in bits [31:10]. A read miss fetches the word at the request address with its two low bits cleared, and returns the memory value.
- R2: A read hit raises cpu_hit and returns the stored word in the same cycle, with cpu_stall low and no memory request.
- R3: All four tags of the indexed set are compared in parallel, and at most one valid way matches.
- R4: A request that misses keeps cpu_stall high until the line is filled. The held request then completes as a hit.
- R5: A write hit updates only the cached word and sets its dirty flag. No memory access takes place, and a later read returns the new word.
- R6: When the victim is dirty, its word is written to memory at the victim's own address before the fill read is issued. A clean victim is dropped with no memory write.
- R7: Any number of write hits to a line between fill and eviction cause exactly one memory write, and that write carries the last value written.
- R8: An invalid way is always chosen as the victim before any valid way, so four different tags in one set all stay resident after reset.
- R9: Each set keeps distinct 2-bit ranks for its four ways, with 0 meaning most recent. Every hit and every fill makes the accessed way rank 0. A miss in a full set evicts the way with rank 3.
- R10: A write miss first reads the line from memory, then merges the write data and marks the line dirty. Memory sees the written value only when the line is evicted.
- R11: After reset all ways are invalid, and cpu_stall, cpu_hit, mem_rd and mem_wr are low while there is no request.
- R12: A memory request (mem_rd or mem_wr) stays asserted with a stable mem_addr until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd | input | 1 | Read request, held until cpu_stall is low |
| cpu_wr | input | 1 | Write request, held until cpu_stall is low |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_hit is high |
| cpu_hit | output | 1 | The current request hits this cycle |
| cpu_stall | output | 1 | The current request must be held |
| mem_addr | output | 32 | Word address toward memory |
| mem_rd | output | 1 | Memory read request (fill) |
| mem_wr | output | 1 | Memory write request (writeback) |
| mem_wdata | output | 32 | Writeback data |
| mem_rdata | input | 32 | Fill data, sampled while mem_ack is high |
| mem_ack | input | 1 | One-cycle completion of the memory request |

## Verification
Several properties are checked on every cycle. At most one way matches, and the ranks of the indexed set form a permutation. A hit never stalls, and a write hit never touches memory. Reads and writes to memory are never issued together. A memory request holds its address until it is acknowledged, and there is no stall without a request. Only the bench's scenarios can show that the right victim is chosen: invalid ways first, then rank-3 eviction after a recency change. They also show that several write hits collapse into one writeback carrying the last value, that the writeback precedes the fill, and that a write miss allocates and later writes back the merged word.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_WBACK = 2'd1,
      CS_FILL  = 2'd2
   } cstate_t;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 22,
   parameter int RANK_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       way_valid,
   input  logic [WAYS*TAG_W-1:0] way_tags,
   input  logic [TAG_W-1:0]      req_tag,
   output logic [WAYS-1:0]       match_vec,
   output logic                  hit,
   output logic [RANK_W-1:0]     hit_way
);
   // one comparator per way, all in parallel
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == req_tag);
   end

   assign hit = |match_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match_vec[w]) hit_way = hit_way | RANK_W'(w);
      end
   end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int WAYS   = 4,
   parameter int SET_W  = 8,
   parameter int RANK_W = $clog2(WAYS),
   parameter int SETS   = 1 << SET_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SET_W-1:0]       set_idx,
   input  logic [WAYS-1:0]        way_valid,
   input  logic                   touch_en,
   input  logic [RANK_W-1:0]      touch_way,
   output logic [RANK_W-1:0]      victim_way,
   output logic [WAYS*RANK_W-1:0] set_ranks
);
   localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

   logic [RANK_W-1:0] rank_q [SETS][WAYS];
   logic [RANK_W-1:0] touched_rank;

   assign touched_rank = rank_q[set_idx][touch_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RANK_W'(w);
         end
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (RANK_W'(w) == touch_way)
               rank_q[set_idx][w] <= '0;
            else if (rank_q[set_idx][w] < touched_rank)
               rank_q[set_idx][w] <= rank_q[set_idx][w] + 1'b1;
         end
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_out
      assign set_ranks[w*RANK_W +: RANK_W] = rank_q[set_idx][w];
   end

   // victim: lowest invalid way, else the oldest rank
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !way_valid[w]) begin
            victim_way = RANK_W'(w);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (rank_q[set_idx][w] == OLDEST) victim_way = RANK_W'(w);
         end
      end
   end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int RANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              lookup_hit,
   input  logic [RANK_W-1:0] victim_way,
   input  logic              victim_dirty,
   input  logic              mem_ack,
   output logic [RANK_W-1:0] vict_q,
   output logic              cpu_hit,
   output logic              cpu_stall,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              fill_en
);
   cstate_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         vict_q <= '0;
      end else begin
         unique case (st_q)
            CS_IDLE: if (req && !lookup_hit) begin
               vict_q <= victim_way;
               st_q   <= victim_dirty ? CS_WBACK : CS_FILL;
            end
            CS_WBACK: if (mem_ack) st_q <= CS_FILL;
            CS_FILL:  if (mem_ack) st_q <= CS_IDLE;
            default:  st_q <= CS_IDLE;
         endcase
      end
   end

   assign cpu_hit   = (st_q == CS_IDLE) && req && lookup_hit;
   assign cpu_stall = req && !cpu_hit;
   assign mem_wr    = (st_q == CS_WBACK);
   assign mem_rd    = (st_q == CS_FILL);
   assign fill_en   = mem_rd && mem_ack;
endmodule

// File: rtl/assoc_cache4.sv
module assoc_cache4 #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SET_W  = 8,
   parameter int WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_hit,
   output logic              cpu_stall,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int OFF_W  = $clog2(DATA_W / 8);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int SETS   = 1 << SET_W;
   localparam int RANK_W = $clog2(WAYS);

   if ((1 << RANK_W) != WAYS || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || (DATA_W % 8) != 0) begin : g_bad_widths
      $error("address or data width does not fit the geometry");
   end

   // address fields
   logic [SET_W-1:0] set_idx;
   logic [TAG_W-1:0] req_tag;
   logic             unused_offset;
   assign set_idx       = cpu_addr[OFF_W +: SET_W];
   assign req_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
   assign unused_offset = &{1'b0, cpu_addr[OFF_W-1:0]};

   // storage
   logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
   logic [DATA_W-1:0] data_mem [SETS][WAYS];
   logic              valid_q  [SETS][WAYS];
   logic              dirty_q  [SETS][WAYS];

   logic [WAYS-1:0]        way_valid;
   logic [WAYS*TAG_W-1:0]  way_tags;
   logic [WAYS*DATA_W-1:0] way_data;
   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign way_valid[w]                 = valid_q[set_idx][w];
      assign way_tags[w*TAG_W +: TAG_W]   = tag_mem[set_idx][w];
      assign way_data[w*DATA_W +: DATA_W] = data_mem[set_idx][w];
   end

   // parallel compare
   logic [WAYS-1:0]   match_vec;
   logic              lookup_hit;
   logic [RANK_W-1:0] hit_way;
   cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W)) u_match (
      .way_valid (way_valid),
      .way_tags  (way_tags),
      .req_tag   (req_tag),
      .match_vec (match_vec),
      .hit       (lookup_hit),
      .hit_way   (hit_way)
   );

   // way select for read data
   assign cpu_rdata = way_data[hit_way*DATA_W +: DATA_W];

   // control
   logic              req;
   logic [RANK_W-1:0] victim_way;
   logic [RANK_W-1:0] vict_q;
   logic              victim_dirty;
   logic              fill_en;
   assign req          = cpu_rd || cpu_wr;
   assign victim_dirty = valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way];

   cache_ctrl #(.RANK_W(RANK_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .lookup_hit   (lookup_hit),
      .victim_way   (victim_way),
      .victim_dirty (victim_dirty),
      .mem_ack      (mem_ack),
      .vict_q       (vict_q),
      .cpu_hit      (cpu_hit),
      .cpu_stall    (cpu_stall),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .fill_en      (fill_en)
   );

   // recency
   logic                   touch_en;
   logic [RANK_W-1:0]      touch_way;
   logic [WAYS*RANK_W-1:0] set_ranks;
   assign touch_en  = cpu_hit || fill_en;
   assign touch_way = fill_en ? vict_q : hit_way;

   cache_lru #(.WAYS(WAYS), .SET_W(SET_W), .RANK_W(RANK_W)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (set_idx),
      .way_valid  (way_valid),
      .touch_en   (touch_en),
      .touch_way  (touch_way),
      .victim_way (victim_way),
      .set_ranks  (set_ranks)
   );

   // memory side
   assign mem_addr  = mem_wr ? {tag_mem[set_idx][vict_q], set_idx, {OFF_W{1'b0}}}
                             : {req_tag, set_idx, {OFF_W{1'b0}}};
   assign mem_wdata = data_mem[set_idx][vict_q];

   // array updates
   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_mem[set_idx][vict_q]  <= req_tag;
         data_mem[set_idx][vict_q] <= mem_rdata;
      end else if (cpu_hit && cpu_wr) begin
         data_mem[set_idx][hit_way] <= cpu_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               valid_q[s][w] <= 1'b0;
               dirty_q[s][w] <= 1'b0;
            end
         end
      end else if (fill_en) begin
         valid_q[set_idx][vict_q] <= 1'b1;
         dirty_q[set_idx][vict_q] <= 1'b0;
      end else if (cpu_hit && cpu_wr) begin
         dirty_q[set_idx][hit_way] <= 1'b1;
      end
   end
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
   parameter int ADDR_W = 32,
   parameter int WAYS   = 4,
   parameter int RANK_W = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cpu_rd,
   input logic                   cpu_wr,
   input logic                   cpu_hit,
   input logic                   cpu_stall,
   input logic                   mem_rd,
   input logic                   mem_wr,
   input logic                   mem_ack,
   input logic [ADDR_W-1:0]      mem_addr,
   input logic [WAYS-1:0]        match_vec,
   input logic [WAYS*RANK_W-1:0] set_ranks
);
   logic [WAYS-1:0] rank_seen;
   always_comb begin
      rank_seen = '0;
      for (int w = 0; w < WAYS; w++)
         rank_seen[set_ranks[w*RANK_W +: RANK_W]] = 1'b1;
   end

   AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R3
   AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> !cpu_stall); // R2
   AST_WRHIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hit && cpu_wr) |-> (!mem_rd && !mem_wr)); // R5
   AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R6
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ack) |=> ((mem_rd || mem_wr) && $stable(mem_addr))); // R12
   AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      rank_seen == {WAYS{1'b1}}); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> (!cpu_stall && !cpu_hit)); // R11
endmodule

bind assoc_cache4 cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS), .RANK_W(RANK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_rd    (cpu_rd),
   .cpu_wr    (cpu_wr),
   .cpu_hit   (cpu_hit),
   .cpu_stall (cpu_stall),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .match_vec (match_vec),
   .set_ranks (set_ranks)
);

// File: tb/tb_assoc_cache4.sv
module tb_assoc_cache4;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_hit, cpu_stall;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #5 clk = ~clk;

   assoc_cache4 dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // memory model: 4096 words, acknowledges after a short latency
   localparam int LAT = 2;
   logic [31:0] store [4096];
   int          rd_cnt = 0, wr_cnt = 0, lat = 0;
   int          last_op = 0, prev_op = 0;
   logic [31:0] last_wr_addr = '0, last_rd_addr = '0, pend_addr = '0;
   logic        pend = 1'b0, hold_err = 1'b0;

   function automatic logic [31:0] init_val(input int i);
      return 32'h5A00_0000 | 32'(i);
   endfunction

   initial for (int i = 0; i < 4096; i++) store[i] = init_val(i);

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; lat <= 0; pend <= 1'b0;
      end else if ((mem_rd || mem_wr) && !mem_ack) begin
         if (pend && mem_addr != pend_addr) hold_err <= 1'b1;
         pend <= 1'b1; pend_addr <= mem_addr;
         if (lat == LAT) begin
            mem_ack <= 1'b1; lat <= 0; pend <= 1'b0;
            prev_op <= last_op;
            if (mem_wr) begin
               store[mem_addr[13:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1;
               last_op <= 1; last_wr_addr <= mem_addr;
            end else begin
               mem_rdata <= store[mem_addr[13:2]]; rd_cnt <= rd_cnt + 1;
               last_op <= 2; last_rd_addr <= mem_addr;
            end
         end else lat <= lat + 1;
      end else mem_ack <= 1'b0;
   end

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] adr(input int tag, input int set);
      return {22'(tag), 8'(set), 2'b00};
   endfunction

   task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                         output logic [31:0] rd, output logic hit1);
      @(negedge clk);
      cpu_addr = a; cpu_wr = w; cpu_rd = !w; cpu_wdata = d;
      #1 hit1 = cpu_hit;
      while (cpu_stall) begin @(negedge clk); #1; end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R11 stall", 32'(cpu_stall), 0);
      chk("R11 hit", 32'(cpu_hit), 0);
      chk("R11 mem req", 32'({mem_rd, mem_wr}), 0);
   endtask

   task automatic t_read_miss_hit;
      logic [31:0] rd; logic h; int r0;
      r0 = rd_cnt;
      access(adr(1, 3) | 32'h2, 1'b0, '0, rd, h);
      chk("R4 first cycle miss", 32'(h), 0);
      chk("R1 fill data", rd, init_val(32'(adr(1, 3)) >> 2));
      chk("R1 fill address", last_rd_addr, adr(1, 3));
      chk("R4 one fill read", 32'(rd_cnt - r0), 1);
      access(adr(1, 3), 1'b0, '0, rd, h);
      chk("R2 hit", 32'(h), 1);
      chk("R2 data", rd, init_val(32'(adr(1, 3)) >> 2));
      chk("R2 no memory read", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_write_hit;
      logic [31:0] rd; logic h; int w0;
      w0 = wr_cnt;
      access(adr(1, 3), 1'b1, 32'h1234_5678, rd, h);
      chk("R5 write hit", 32'(h), 1);
      access(adr(1, 3), 1'b0, '0, rd, h);
      chk("R5 readback", rd, 32'h1234_5678);
      chk("R5 no memory write", 32'(wr_cnt - w0), 0);
      chk("R5 memory stale", store[adr(1, 3) >> 2], init_val(32'(adr(1, 3)) >> 2));
   endtask

   task automatic t_invalid_first;
      logic [31:0] rd; logic h; int r0;
      for (int t = 0; t < 4; t++) access(adr(t, 9), 1'b0, '0, rd, h);
      r0 = rd_cnt;
      for (int t = 0; t < 4; t++) begin
         access(adr(t, 9), 1'b0, '0, rd, h);
         chk("R8 resident", 32'(h), 1);
      end
      chk("R8 no refetch", 32'(rd_cnt - r0), 0);
   endtask

   task automatic t_lru;
      logic [31:0] rd; logic h;
      for (int t = 0; t < 4; t++) access(adr(t, 7), 1'b0, '0, rd, h);
      access(adr(0, 7), 1'b0, '0, rd, h);   // tag 0 becomes most recent
      access(adr(4, 7), 1'b0, '0, rd, h);   // evicts tag 1
      access(adr(0, 7), 1'b0, '0, rd, h); chk("R9 tag0 kept", 32'(h), 1);
      access(adr(2, 7), 1'b0, '0, rd, h); chk("R9 tag2 kept", 32'(h), 1);
      access(adr(3, 7), 1'b0, '0, rd, h); chk("R9 tag3 kept", 32'(h), 1);
      access(adr(4, 7), 1'b0, '0, rd, h); chk("R9 tag4 kept", 32'(h), 1);
      access(adr(1, 7), 1'b0, '0, rd, h); chk("R9 tag1 evicted", 32'(h), 0);
   endtask

   task automatic t_writeback;
      logic [31:0] rd; logic h; int w0;
      for (int t = 0; t < 4; t++) access(adr(t, 5), 1'b0, '0, rd, h);
      access(adr(0, 5), 1'b1, 32'h0000_0001, rd, h);
      access(adr(0, 5), 1'b1, 32'h0000_0002, rd, h);
      access(adr(0, 5), 1'b1, 32'h0000_0003, rd, h);
      w0 = wr_cnt;
      for (int t = 4; t < 7; t++) access(adr(t, 5), 1'b0, '0, rd, h);
      chk("R6 clean victims no write", 32'(wr_cnt - w0), 0);
      access(adr(7, 5), 1'b0, '0, rd, h);   // evicts dirty tag 0
      chk("R7 single writeback", 32'(wr_cnt - w0), 1);
      chk("R7 last value", store[adr(0, 5) >> 2], 32'h0000_0003);
      chk("R6 victim address", last_wr_addr, adr(0, 5));
      chk("R6 write before fill", 32'({prev_op[1:0], last_op[1:0]}), 32'h6);
      chk("R6 fill data", rd, init_val(32'(adr(7, 5)) >> 2));
   endtask

   task automatic t_write_miss;
      logic [31:0] rd; logic h; int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      access(adr(2, 11), 1'b1, 32'hDEAD_BEEF, rd, h);
      chk("R10 miss", 32'(h), 0);
      chk("R10 fetch first", 32'(rd_cnt - r0), 1);
      chk("R10 no write yet", 32'(wr_cnt - w0), 0);
      access(adr(2, 11), 1'b0, '0, rd, h);
      chk("R10 merged", rd, 32'hDEAD_BEEF);
      for (int t = 3; t < 7; t++) access(adr(t, 11), 1'b0, '0, rd, h);
      chk("R10 dirty writeback", 32'(wr_cnt - w0), 1);
      chk("R10 memory value", store[adr(2, 11) >> 2], 32'hDEAD_BEEF);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_read_miss_hit();
      t_write_hit();
      t_invalid_first();
      t_lru();
      t_writeback();
      t_write_miss();
      chk("R12 address held", 32'(hold_err), 0);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule